// File: doc/BRIEF.md
# Pass-Parallel Significance State Unit

This unit serves a bit-plane entropy coder that evaluates all three fractional coding passes in one scan. In each cycle it takes two vertically adjacent samples of a stripe column, called the upper sample A and the lower sample B, together with their 3-wide neighbourhood. For each of the two samples it decides which pass codes it in the current bit-plane. It also works out the neighbour significance that sample must see for context formation, and it returns updated state bits to be written back.

Each sample carries two stored significance bits. The first (`sig0`) records significance reached in the propagation pass. The second (`sig1`) records significance reached in the cleanup pass. Their XOR marks a sample whose next refinement is its first one. A and B are classified in the same cycle, so the unit predicts A's significance as B sees it. The prediction uses A's own pass and magnitude bit. The row below B is treated as insignificant when B is the last row of a stripe.

All results are registered, and they appear one cycle after the inputs are accepted.

Top module: `pps_sig_state`

## Requirements
- R1: Results for a pair presented with `in_valid_i` high appear on the outputs one cycle later with `out_valid_o` high. A cycle with `in_valid_i` low gives `out_valid_o` low one cycle later. Synchronous reset clears `out_valid_o` and every result output to 0.
- R2: Pass codes are 2'b01 = propagation, 2'b10 = refinement, 2'b11 = cleanup. A sample with `sig0|sig1` = 1 is refinement. An insignificant sample with at least one set bit in its propagation-view neighbour vector is propagation. Any other sample is cleanup.
- R3: `refine_first_o[s]` is 1 exactly when sample s (bit 0 = A, bit 1 = B) is refinement and its stored `sig0 ^ sig1` is 1.
- R4: Write-back values depend on the pass. Propagation gives `sig0 |= mag`. Refinement sets both bits to 1. Cleanup gives `sig1 |= mag`. A bit not named for a pass keeps its stored value.
- R5: Window position p = 3*row + col. Rows 0..3 are: above A, A, B, below B. Cols 0..2 are: left, current, right. The neighbour vector bit order is NW, N, NE, W, E, SW, S, SE, in bits 0..7. `coded_i` holds the 10 non-centre positions in row-major order. In the propagation and refinement views, a coded neighbour contributes its `sig0`.
- R6: In the propagation and cleanup views, an uncoded neighbour contributes `sig0|sig1`. In the refinement view it contributes `sig0|sig1|mag`. In the cleanup view a coded neighbour also contributes `sig0|sig1`.
- R7: A sees B (its S bit) as an uncoded neighbour, whatever the coded flags say.
- R8: In B's propagation and refinement views, B's N bit is `sig0[A] | x`. Here x is `mag[A]` if A is propagation, 1 if A is refinement, and 0 if A is cleanup.
- R9: In B's cleanup view, B's N bit is `sig0[A] | mag[A]`.
- R10: With `stripe_base_i` high, B's SW, S and SE bits read 0, and row 3 plays no part in B's classification.
- R11: Each output neighbour vector is the view that matches the sample's own pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Window inputs valid this cycle |
| stripe_base_i | input | 1 | B is the last row of its stripe; row 3 lies in the next stripe |
| mag_i | input | 12 | Current magnitude bit per window position |
| sig0_i | input | 12 | Stored propagation-pass significance per position |
| sig1_i | input | 12 | Stored cleanup-pass significance per position |
| coded_i | input | 10 | Already-coded flag for the non-centre positions |
| out_valid_o | output | 1 | Results valid |
| pass_a_o | output | 2 | Pass code of A |
| pass_b_o | output | 2 | Pass code of B |
| nbr_a_o | output | 8 | Effective neighbour significance seen by A |
| nbr_b_o | output | 8 | Effective neighbour significance seen by B |
| refine_first_o | output | 2 | First-refinement flag, bit 0 = A, bit 1 = B |
| wb_sig0_o | output | 2 | Updated sig0, bit 0 = A, bit 1 = B |
| wb_sig1_o | output | 2 | Updated sig1, bit 0 = A, bit 1 = B |

## Verification
Every result of this unit (pass codes, both neighbour vectors, the refinement flag and both write-back pairs) is due exactly one clock edge after the window is driven. The bench therefore drives a window on a falling edge, computes the expected result from its own sequential model right away, and compares on the next falling edge, after the single register stage has loaded. Idle cycles and reset are observed on that same one-cycle grid. Stimulus walks all 64 combinations of the pair's own bits against random surroundings. Directed windows cover the prediction cases and the stripe-base cut.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int ROWS    = 4;
    localparam int COLS    = 3;
    localparam int POS     = ROWS * COLS;
    localparam int NBRS    = 8;
    localparam int OUTER   = POS - 2;
    localparam int PAIR    = 2;
    localparam int A_POS   = 1 * COLS + 1;
    localparam int B_POS   = 2 * COLS + 1;
    localparam int K_NORTH = 1;

    typedef enum logic [1:0] {
        PASS_NONE = 2'b00,
        PASS_SP   = 2'b01,
        PASS_MR   = 2'b10,
        PASS_CU   = 2'b11
    } pass_e;

    typedef struct packed {
        logic mag;
        logic s0;
        logic s1;
        logic coded;
        logic live;
    } nbr_t;

    // row / column offset of neighbour slot k (NW,N,NE,W,E,SW,S,SE)
    function automatic int nbr_dr(input int k);
        return (k < 3) ? -1 : ((k < 5) ? 0 : 1);
    endfunction

    function automatic int nbr_dc(input int k);
        if (k < 3)       return k - 1;
        else if (k == 3) return -1;
        else if (k == 4) return 1;
        else             return k - 6;
    endfunction

    // index into the packed coded-flag vector for a non-centre position
    function automatic int coded_idx(input int r, input int c);
        if (r == 0)      return c;
        else if (r == 1) return (c == 0) ? 3 : 4;
        else if (r == 2) return (c == 0) ? 5 : 6;
        else             return 7 + c;
    endfunction

    function automatic logic view_bit(input pass_e v, input nbr_t n);
        logic any_sig;
        any_sig = n.s0 | n.s1;
        case (v)
            PASS_SP: view_bit = n.coded ? n.s0 : any_sig;
            PASS_MR: view_bit = n.coded ? n.s0 : (any_sig | n.mag);
            default: view_bit = any_sig;
        endcase
    endfunction

    function automatic logic [NBRS-1:0] pick_view(input pass_e p,
                                                  input logic [NBRS-1:0] sp,
                                                  input logic [NBRS-1:0] mr,
                                                  input logic [NBRS-1:0] cu);
        case (p)
            PASS_SP: pick_view = sp;
            PASS_MR: pick_view = mr;
            default: pick_view = cu;
        endcase
    endfunction

endpackage

// File: rtl/pps_nbr_view.sv
module pps_nbr_view
    import pps_pkg::*;
(
    input  nbr_t [NBRS-1:0] nbr_i,
    output logic [NBRS-1:0] v_sp_o,
    output logic [NBRS-1:0] v_mr_o,
    output logic [NBRS-1:0] v_cu_o
);
    for (genvar k = 0; k < NBRS; k++) begin : g_slot
        assign v_sp_o[k] = nbr_i[k].live & view_bit(PASS_SP, nbr_i[k]);
        assign v_mr_o[k] = nbr_i[k].live & view_bit(PASS_MR, nbr_i[k]);
        assign v_cu_o[k] = nbr_i[k].live & view_bit(PASS_CU, nbr_i[k]);
    end
endmodule

// File: rtl/pps_pass_classify.sv
module pps_pass_classify
    import pps_pkg::*;
(
    input  logic  s0_i,
    input  logic  s1_i,
    input  logic  any_sp_i,
    output pass_e pass_o
);
    always_comb begin
        if (s0_i | s1_i)   pass_o = PASS_MR;
        else if (any_sp_i) pass_o = PASS_SP;
        else               pass_o = PASS_CU;
    end
endmodule

// File: rtl/pps_state_update.sv
module pps_state_update
    import pps_pkg::*;
(
    input  pass_e pass_i,
    input  logic  s0_i,
    input  logic  s1_i,
    input  logic  mag_i,
    output logic  s0_o,
    output logic  s1_o,
    output logic  refine_first_o
);
    always_comb begin
        s0_o           = s0_i;
        s1_o           = s1_i;
        refine_first_o = 1'b0;
        case (pass_i)
            PASS_SP: s0_o = s0_i | mag_i;
            PASS_MR: begin
                s0_o           = 1'b1;
                s1_o           = 1'b1;
                refine_first_o = s0_i ^ s1_i;
            end
            PASS_CU: s1_o = s1_i | mag_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/pps_sig_state.sv
module pps_sig_state
    import pps_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic              stripe_base_i,
    input  logic [POS-1:0]    mag_i,
    input  logic [POS-1:0]    sig0_i,
    input  logic [POS-1:0]    sig1_i,
    input  logic [OUTER-1:0]  coded_i,
    output logic              out_valid_o,
    output logic [1:0]        pass_a_o,
    output logic [1:0]        pass_b_o,
    output logic [NBRS-1:0]   nbr_a_o,
    output logic [NBRS-1:0]   nbr_b_o,
    output logic [PAIR-1:0]   refine_first_o,
    output logic [PAIR-1:0]   wb_sig0_o,
    output logic [PAIR-1:0]   wb_sig1_o
);
    nbr_t [NBRS-1:0] nb_raw [PAIR];
    logic [NBRS-1:0] v_sp [PAIR];
    logic [NBRS-1:0] v_mr [PAIR];
    logic [NBRS-1:0] v_cu [PAIR];

    // gather the neighbourhood of each sample of the pair
    for (genvar gs = 0; gs < PAIR; gs++) begin : g_samp
        for (genvar gk = 0; gk < NBRS; gk++) begin : g_nbr
            localparam int R  = gs + 1 + nbr_dr(gk);
            localparam int C  = 1 + nbr_dc(gk);
            localparam int P  = R * COLS + C;
            localparam bit IN_PAIR = (C == 1) && (R == 1 || R == 2);
            logic coded_w;
            logic live_w;
            if (IN_PAIR) begin : g_pair
                assign coded_w = 1'b0;          // partner is never coded yet
            end else begin : g_out
                assign coded_w = coded_i[coded_idx(R, C)];
            end
            if (R == ROWS - 1) begin : g_low
                assign live_w = ~stripe_base_i; // stripe-causal cut
            end else begin : g_up
                assign live_w = 1'b1;
            end
            assign nb_raw[gs][gk] = '{mag: mag_i[P], s0: sig0_i[P], s1: sig1_i[P],
                                      coded: coded_w, live: live_w};
        end

        pps_nbr_view u_view (
            .nbr_i  (nb_raw[gs]),
            .v_sp_o (v_sp[gs]),
            .v_mr_o (v_mr[gs]),
            .v_cu_o (v_cu[gs])
        );
    end

    // upper sample classification
    pass_e pass_a;
    pps_pass_classify u_cls_a (
        .s0_i     (sig0_i[A_POS]),
        .s1_i     (sig1_i[A_POS]),
        .any_sp_i (|v_sp[0]),
        .pass_o   (pass_a)
    );

    // lower sample sees a predicted upper sample
    logic            sp_term;
    logic [NBRS-1:0] eff_sp_b, eff_mr_b, eff_cu_b;
    always_comb begin
        case (pass_a)
            PASS_SP: sp_term = mag_i[A_POS];
            PASS_MR: sp_term = 1'b1;
            default: sp_term = 1'b0;
        endcase
        eff_sp_b          = v_sp[1];
        eff_mr_b          = v_mr[1];
        eff_cu_b          = v_cu[1];
        eff_sp_b[K_NORTH] = sig0_i[A_POS] | sp_term;
        eff_mr_b[K_NORTH] = sig0_i[A_POS] | sp_term;
        eff_cu_b[K_NORTH] = sig0_i[A_POS] | mag_i[A_POS];
    end

    pass_e pass_b;
    pps_pass_classify u_cls_b (
        .s0_i     (sig0_i[B_POS]),
        .s1_i     (sig1_i[B_POS]),
        .any_sp_i (|eff_sp_b),
        .pass_o   (pass_b)
    );

    // per-sample state write-back
    pass_e         pass_arr [PAIR];
    logic [PAIR-1:0] s0n, s1n, rf;
    assign pass_arr[0] = pass_a;
    assign pass_arr[1] = pass_b;

    for (genvar gs = 0; gs < PAIR; gs++) begin : g_upd
        localparam int SP = (gs == 0) ? A_POS : B_POS;
        pps_state_update u_upd (
            .pass_i         (pass_arr[gs]),
            .s0_i           (sig0_i[SP]),
            .s1_i           (sig1_i[SP]),
            .mag_i          (mag_i[SP]),
            .s0_o           (s0n[gs]),
            .s1_o           (s1n[gs]),
            .refine_first_o (rf[gs])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_valid_o    <= 1'b0;
            pass_a_o       <= '0;
            pass_b_o       <= '0;
            nbr_a_o        <= '0;
            nbr_b_o        <= '0;
            refine_first_o <= '0;
            wb_sig0_o      <= '0;
            wb_sig1_o      <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                pass_a_o       <= pass_a;
                pass_b_o       <= pass_b;
                nbr_a_o        <= pick_view(pass_a, v_sp[0], v_mr[0], v_cu[0]);
                nbr_b_o        <= pick_view(pass_b, eff_sp_b, eff_mr_b, eff_cu_b);
                refine_first_o <= rf;
                wb_sig0_o      <= s0n;
                wb_sig1_o      <= s1n;
            end
        end
    end
endmodule

// File: rtl/pps_sig_state_chk.sv
module pps_sig_state_chk
    import pps_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_valid_i,
    input logic             stripe_base_i,
    input logic [POS-1:0]   sig0_i,
    input logic             out_valid_o,
    input logic [1:0]       pass_a_o,
    input logic [1:0]       pass_b_o,
    input logic [NBRS-1:0]  nbr_a_o,
    input logic [NBRS-1:0]  nbr_b_o,
    input logic [PAIR-1:0]  refine_first_o,
    input logic [PAIR-1:0]  wb_sig0_o,
    input logic [PAIR-1:0]  wb_sig1_o
);
    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o);                                          // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !out_valid_o);                                        // R1
    AST_PASS_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> (pass_a_o != 2'b00 && pass_b_o != 2'b00));            // R2
    AST_SP_HAS_NEIGHBOUR: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> ((pass_a_o != 2'b01 || |nbr_a_o) &&
                         (pass_b_o != 2'b01 || |nbr_b_o)));                   // R2
    AST_REFINE_IMPLIES_MR: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> ((!refine_first_o[0] || pass_a_o == 2'b10) &&
                         (!refine_first_o[1] || pass_b_o == 2'b10)));         // R3
    AST_MR_WRITEBACK_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> ((pass_a_o != 2'b10 || (wb_sig0_o[0] && wb_sig1_o[0])) &&
                         (pass_b_o != 2'b10 || (wb_sig0_o[1] && wb_sig1_o[1]))));  // R4
    AST_WB_NEVER_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> ((wb_sig0_o & {$past(sig0_i[B_POS]), $past(sig0_i[A_POS])})
                        == {$past(sig0_i[B_POS]), $past(sig0_i[A_POS])}));   // R4
    AST_STRIPE_BASE_MASK: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && stripe_base_i) |=> (nbr_b_o[7:5] == 3'b000));          // R10
endmodule

bind pps_sig_state pps_sig_state_chk u_chk (.*);

// File: tb/pps_sig_state_test.sv
module pps_sig_state_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        stripe_base;
    logic [11:0] mag, sig0, sig1;
    logic [9:0]  coded;
    logic        out_valid;
    logic [1:0]  pass_a, pass_b, rf, w0, w1;
    logic [7:0]  nbr_a, nbr_b;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pps_sig_state uut (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .stripe_base_i(stripe_base),
        .mag_i(mag), .sig0_i(sig0), .sig1_i(sig1), .coded_i(coded),
        .out_valid_o(out_valid), .pass_a_o(pass_a), .pass_b_o(pass_b),
        .nbr_a_o(nbr_a), .nbr_b_o(nbr_b), .refine_first_o(rf),
        .wb_sig0_o(w0), .wb_sig1_o(w1)
    );

    // coded flag of a non-centre position, counted in row-major scan
    function automatic logic coded_at(int r, int c);
        int n = 0;
        for (int rr = 0; rr < 4; rr++)
            for (int cc = 0; cc < 3; cc++) begin
                if (cc == 1 && (rr == 1 || rr == 2)) continue;
                if (rr == r && cc == c) return coded[n];
                n++;
            end
        return 1'b0;
    endfunction

    // neighbour contribution in pass view v (1,2,3)
    function automatic logic contrib(int v, int p, logic cd);
        if (v == 3) return sig0[p] | sig1[p];
        if (cd)     return sig0[p];
        if (v == 1) return sig0[p] | sig1[p];
        return sig0[p] | sig1[p] | mag[p];
    endfunction

    function automatic logic [7:0] ref_vec(int rs, int v, int pa);
        logic [7:0] out = '0;
        int k = 0;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++) begin
                int r, c;
                if (dr == 0 && dc == 0) continue;
                r = rs + dr;
                c = 1 + dc;
                if (r == 3 && stripe_base)               out[k] = 1'b0;
                else if (rs == 2 && r == 1 && c == 1) begin
                    if (v == 3)       out[k] = sig0[4] | mag[4];
                    else if (pa == 1) out[k] = sig0[4] | mag[4];
                    else if (pa == 2) out[k] = 1'b1;
                    else              out[k] = sig0[4];
                end else if (c == 1 && (r == 1 || r == 2)) out[k] = contrib(v, r*3+c, 1'b0);
                else                                       out[k] = contrib(v, r*3+c, coded_at(r, c));
                k++;
            end
        return out;
    endfunction

    function automatic int ref_pass(int rs, int pa);
        int p = rs * 3 + 1;
        if (sig0[p] | sig1[p]) return 2;
        if (|ref_vec(rs, 1, pa)) return 1;
        return 3;
    endfunction

    logic [1:0] e_pa, e_pb, e_rf, e_w0, e_w1;
    logic [7:0] e_na, e_nb;

    task automatic model();
        int pa, pb;
        int ps [2];
        pa = ref_pass(1, 0);
        pb = ref_pass(2, pa);
        ps[0] = pa; ps[1] = pb;
        e_pa = 2'(pa);
        e_pb = 2'(pb);
        e_na = ref_vec(1, pa, 0);
        e_nb = ref_vec(2, pb, pa);
        for (int s = 0; s < 2; s++) begin
            int p = (s + 1) * 3 + 1;
            e_rf[s] = (ps[s] == 2) && (sig0[p] != sig1[p]);
            e_w0[s] = (ps[s] == 2) ? 1'b1 : ((ps[s] == 1) ? (sig0[p] | mag[p]) : sig0[p]);
            e_w1[s] = (ps[s] == 2) ? 1'b1 : ((ps[s] == 3) ? (sig1[p] | mag[p]) : sig1[p]);
        end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (vector %0d)", tag, act, exp, n_vec);
        end
    endtask

    // drive one window, check one cycle later
    task automatic apply(logic sb, logic [11:0] m, logic [11:0] a, logic [11:0] b, logic [9:0] cd);
        @(negedge clk);
        in_valid = 1'b1; stripe_base = sb; mag = m; sig0 = a; sig1 = b; coded = cd;
        model();
        @(negedge clk);
        n_vec++;
        chk("R1 out_valid", {7'd0, out_valid}, 8'd1);
        chk("R2 pass_a", {6'd0, pass_a}, {6'd0, e_pa});
        chk("R2 pass_b (R8 prediction)", {6'd0, pass_b}, {6'd0, e_pb});
        chk("R5 R6 R7 R11 nbr_a", nbr_a, e_na);
        chk("R8 R9 R10 R11 nbr_b", nbr_b, e_nb);
        chk("R3 refine_first", {6'd0, rf}, {6'd0, e_rf});
        chk("R4 wb_sig0", {6'd0, w0}, {6'd0, e_w0});
        chk("R4 wb_sig1", {6'd0, w1}, {6'd0, e_w1});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20061));
        rst = 1'b1; in_valid = 1'b0; stripe_base = 1'b0;
        mag = '0; sig0 = '0; sig1 = '0; coded = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        chk("R1 reset out_valid", {7'd0, out_valid}, 8'd0);
        chk("R1 reset nbr/pass", {nbr_a[3:0], pass_a, pass_b}, 8'd0);
        rst = 1'b0;

        // all quiet: both cleanup, empty vectors (R2 R11)
        apply(1'b0, 12'h000, 12'h000, 12'h000, 10'h000);
        // R7: only B significant -> A propagation through its S neighbour
        apply(1'b0, 12'h000, 12'h080, 12'h000, 10'h3FF);
        // R8: A propagation with mag 1 -> B propagation via predicted N
        apply(1'b0, 12'h010, 12'h001, 12'h000, 10'h001);
        // R8: A refinement -> B sees N set
        apply(1'b0, 12'h000, 12'h000, 12'h010, 10'h000);
        // R9: A cleanup with mag 1 -> B cleanup, N bit 1 in cleanup view
        apply(1'b0, 12'h010, 12'h000, 12'h000, 10'h000);
        // R10: row below significant but stripe base cuts it
        apply(1'b1, 12'h000, 12'hE00, 12'hE00, 10'h000);
        apply(1'b0, 12'h000, 12'hE00, 12'hE00, 10'h000);
        // R5 R6: coded neighbour with sig1 only, pass-1 view ignores it
        apply(1'b0, 12'h000, 12'h000, 12'h001, 10'h001);
        apply(1'b0, 12'h000, 12'h000, 12'h001, 10'h000);
        // R3 R4: first refinement versus later refinement
        apply(1'b0, 12'h090, 12'h010, 12'h090, 10'h000);

        // R1: idle cycle gives no valid
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        n_vec++;
        chk("R1 idle out_valid", {7'd0, out_valid}, 8'd0);

        // every combination of the pair's own bits against random surroundings
        for (int combo = 0; combo < 64; combo++) begin
            for (int rep = 0; rep < 30; rep++) begin
                logic [11:0] m, a, b;
                m = 12'($urandom); a = 12'($urandom) & 12'($urandom); b = 12'($urandom) & 12'($urandom);
                m[4] = combo[0]; a[4] = combo[1]; b[4] = combo[2];
                m[7] = combo[3]; a[7] = combo[4]; b[7] = combo[5];
                apply(1'($urandom), m, a, b, 10'($urandom));
            end
        end
        // fully random windows
        for (int i = 0; i < 1000; i++)
            apply(1'($urandom), 12'($urandom), 12'($urandom), 12'($urandom), 10'($urandom));

        @(negedge clk); in_valid = 1'b0;
        finish_run();
    end
endmodule